// File: doc/BRIEF.md
# Instruction-Fetch Patch and Remap Unit

This block sits on the address path between a processor's instruction-fetch and constant-load ports and its code memory. Software programs a small set of address comparators. When an instruction fetch or a literal read in code space hits an enabled comparator, the block replaces the outgoing address with a word in an SRAM patch table. The patch word stored there is returned in place of the original code or constant. No exception or stall is raised. Every other access passes through unchanged.

Ten 32-bit registers set up the unit. Index 0 is the control word and index 1 is the table base. Indices 2 to 7 hold the six fetch comparators and indices 8 and 9 hold the two literal comparators. Address substitution is purely combinational, so it adds no cycle to the request path. A register write changes the mapping starting with the clock edge that completes the write.

Top module: `fetch_patch_remap`

## Requirements
- R1: After reset, the unit is transparent. Reads return 0x00000000 for the control word, 0x20000000 for the table base and 0x00000000 for every comparator, and `out_addr` equals `req_addr` with `out_remapped` low.
- R2: A write to index 0 takes effect only when data bit 1 (the key) is set, in which case the global enable takes data bit 0. A keyless write leaves the control word unchanged, and the control word reads back with only bit 0 possibly set.
- R3: While the global enable is clear, no access is remapped, even if it hits an enabled comparator.
- R4: A comparator word holds a match address in bits [28:2] and its own enable in bit 0, and all other bits read as zero. A comparator written with bit 0 clear never matches.
- R5: Comparators at indices 2 to 7 only apply when `req_is_lit` is 0 (instruction fetch). Comparators at indices 8 and 9 only apply when `req_is_lit` is 1 (literal read).
- R6: On a hit, `out_addr` = {3'b001, base[28:5], slot[2:0], req_addr[1:0]}. Fetch comparator k uses slot k (0 to 5), and literal comparator j uses slot 6+j.
- R7: When several enabled comparators hit at once, the one with the lowest slot number wins.
- R8: Only requests with `req_addr[31:29]` = 0 are eligible to match. The match compares `req_addr[28:2]` and ignores `req_addr[1:0]`. Any other address passes through unmodified.
- R9: The table base register stores bits [28:5] of a write. It reads back with bits [31:29] = 3'b001 and all other bits zero.
- R10: Substitution is combinational. A register write applies to requests from the clock edge that accepts it onward, and not before.
- R11: `out_remapped` is high exactly when `out_addr` has been substituted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index (0 to 9) for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data of the register at `cfg_addr` |
| req_addr | input | 32 | Incoming access address |
| req_is_lit | input | 1 | 1 = literal data read, 0 = instruction fetch |
| out_addr | output | 32 | Address sent to memory, substituted or passed through |
| out_remapped | output | 1 | High when `out_addr` points into the patch table |

## Verification
A corrupted comparator or enable bit shows up as a wrong `out_addr` on the first request after the write that set it, because no pipeline stage lies in between. The register readback exposes the stored fields in the same cycle. A priority fault only shows when two comparators hold the same address, so the tests program overlapping entries on purpose. Timing faults are caught by sampling the same request just before and just after the edge that accepts a write.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    // Address field compared against a request (word address inside code space)
    localparam int CMP_LSB = 2;
    localparam int CMP_MSB = 28;
    localparam int CMP_W   = CMP_MSB - CMP_LSB + 1;
    // Control word bits
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_KEY_BIT = 1;
    // Region bits: eligible code space and the fixed SRAM region of the table
    localparam logic [2:0] CODE_REGION = 3'b000;
    localparam logic [2:0] SRAM_REGION = 3'b001;
endpackage

// File: rtl/fpr_regs.sv
module fpr_regs
    import fpr_pkg::*;
#(
    parameter int NUM_INST = 6,
    parameter int NUM_LIT  = 2,
    localparam int NUM_CMP  = NUM_INST + NUM_LIT,
    localparam int NUM_REG  = NUM_CMP + 2,
    localparam int REG_AW   = $clog2(NUM_REG),
    localparam int SLOT_W   = $clog2(NUM_CMP),
    localparam int BASE_LSB = SLOT_W + 2,
    localparam int BASE_W   = CMP_MSB - BASE_LSB + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [REG_AW-1:0]                cfg_addr,
    input  logic [31:0]                      cfg_wdata,
    output logic [31:0]                      cfg_rdata,
    output logic                             glob_en,
    output logic [NUM_CMP-1:0]               cmp_en,
    output logic [NUM_CMP-1:0][CMP_W-1:0]    cmp_addr,
    output logic [BASE_W-1:0]                base
);
    typedef struct packed {
        logic                          glob_en;
        logic [NUM_CMP-1:0]            cmp_en;
        logic [NUM_CMP-1:0][CMP_W-1:0] cmp_addr;
        logic [BASE_W-1:0]             base;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;
    assign unused_wdata = ^cfg_wdata[31:29];

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            if (cfg_addr == REG_AW'(0)) begin
                if (cfg_wdata[CTRL_KEY_BIT]) r_d.glob_en = cfg_wdata[CTRL_EN_BIT];
            end else if (cfg_addr == REG_AW'(1)) begin
                r_d.base = cfg_wdata[CMP_MSB:BASE_LSB];
            end
            for (int i = 0; i < NUM_CMP; i++) begin
                if (cfg_addr == REG_AW'(i + 2)) begin
                    r_d.cmp_en[i]   = cfg_wdata[0];
                    r_d.cmp_addr[i] = cfg_wdata[CMP_MSB:CMP_LSB];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == REG_AW'(0)) cfg_rdata[CTRL_EN_BIT] = r_q.glob_en;
        if (cfg_addr == REG_AW'(1)) cfg_rdata = {SRAM_REGION, r_q.base, {BASE_LSB{1'b0}}};
        for (int i = 0; i < NUM_CMP; i++) begin
            if (cfg_addr == REG_AW'(i + 2))
                cfg_rdata = {3'b000, r_q.cmp_addr[i], 1'b0, r_q.cmp_en[i]};
        end
    end

    assign glob_en  = r_q.glob_en;
    assign cmp_en   = r_q.cmp_en;
    assign cmp_addr = r_q.cmp_addr;
    assign base     = r_q.base;

    // R2: a control write without the key leaves the enable untouched
    a_r2_keyless_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_AW'(0) && !cfg_wdata[CTRL_KEY_BIT]) |=> $stable(glob_en));
    // R10: registers only move on an accepted write
    a_r10_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(cmp_en) && $stable(base) && $stable(glob_en)));
endmodule

// File: rtl/fpr_match.sv
module fpr_match
    import fpr_pkg::*;
#(
    parameter int NUM_INST = 6,
    parameter int NUM_LIT  = 2,
    localparam int NUM_CMP = NUM_INST + NUM_LIT,
    localparam int SLOT_W  = $clog2(NUM_CMP)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          glob_en,
    input  logic [NUM_CMP-1:0]            cmp_en,
    input  logic [NUM_CMP-1:0][CMP_W-1:0] cmp_addr,
    input  logic [31:0]                   req_addr,
    input  logic                          req_is_lit,
    output logic                          hit,
    output logic [SLOT_W-1:0]             slot
);
    logic [NUM_CMP-1:0] cand;
    logic               eligible;

    assign eligible = glob_en && (req_addr[31:29] == CODE_REGION);

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam bit IS_LIT = (g >= NUM_INST);
        assign cand[g] = cmp_en[g]
                      && (cmp_addr[g] == req_addr[CMP_MSB:CMP_LSB])
                      && (req_is_lit == IS_LIT);
    end

    // Lowest slot wins: scan from the top so the last assignment is the lowest
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (eligible && cand[i]) begin
                hit  = 1'b1;
                slot = SLOT_W'(i);
            end
        end
    end

    // R5: the class of the winning comparator follows the access type
    a_r5_lit_slot_class: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && req_is_lit) |-> (int'(slot) >= NUM_INST));
    a_r5_fetch_slot_class: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !req_is_lit) |-> (int'(slot) < NUM_INST));
    // R4: only an enabled comparator can win
    a_r4_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cmp_en[slot]);
endmodule

// File: rtl/fetch_patch_remap.sv
module fetch_patch_remap
    import fpr_pkg::*;
#(
    parameter int NUM_INST = 6,
    parameter int NUM_LIT  = 2,
    localparam int NUM_CMP = NUM_INST + NUM_LIT,
    localparam int REG_AW  = $clog2(NUM_CMP + 2),
    localparam int SLOT_W  = $clog2(NUM_CMP),
    localparam int BASE_W  = CMP_MSB - (SLOT_W + 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       req_addr,
    input  logic              req_is_lit,
    output logic [31:0]       out_addr,
    output logic              out_remapped
);
    logic                          glob_en;
    logic [NUM_CMP-1:0]            cmp_en;
    logic [NUM_CMP-1:0][CMP_W-1:0] cmp_addr;
    logic [BASE_W-1:0]             base;
    logic                          hit;
    logic [SLOT_W-1:0]             slot;

    fpr_regs #(.NUM_INST(NUM_INST), .NUM_LIT(NUM_LIT)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .glob_en(glob_en),
        .cmp_en(cmp_en), .cmp_addr(cmp_addr), .base(base)
    );

    fpr_match #(.NUM_INST(NUM_INST), .NUM_LIT(NUM_LIT)) i_match (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cmp_en(cmp_en),
        .cmp_addr(cmp_addr), .req_addr(req_addr), .req_is_lit(req_is_lit),
        .hit(hit), .slot(slot)
    );

    always_comb begin
        out_addr     = req_addr;
        out_remapped = hit;
        if (hit) out_addr = {SRAM_REGION, base, slot, req_addr[1:0]};
    end

    // R3: global enable clear means fully transparent
    a_r3_disabled_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (out_addr == req_addr && !out_remapped));
    // R8: accesses outside code space are never touched
    a_r8_outside_code_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[31:29] != CODE_REGION) |-> (out_addr == req_addr && !out_remapped));
    // R6: a substituted address lands in SRAM and keeps the byte lane
    a_r6_target_in_sram: assert property (@(posedge clk) disable iff (!rst_n)
        out_remapped |-> (out_addr[31:29] == SRAM_REGION && out_addr[1:0] == req_addr[1:0]));
endmodule

// File: tb/test_fetch_patch_remap.sv
module test_fetch_patch_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] req_addr = '0;
    logic        req_is_lit = 1'b0;
    logic [31:0] out_addr;
    logic        out_remapped;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fetch_patch_remap i_fetch_patch_remap (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
        .req_is_lit(req_is_lit), .out_addr(out_addr), .out_remapped(out_remapped)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] idx, logic [31:0] exp);
        @(negedge clk);
        cfg_addr = idx;
        #1 chk(req, cfg_rdata, exp);
    endtask

    task automatic acc_chk(string req, logic [31:0] a, logic lit, logic [31:0] exp, logic exp_hit);
        @(negedge clk);
        req_addr = a; req_is_lit = lit;
        #1;
        chk(req, out_addr, exp);
        chk({req, " flag R11"}, {31'd0, out_remapped}, {31'd0, exp_hit});
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 4'd0, 32'h0);
        rd_chk("R1 base", 4'd1, 32'h2000_0000);
        rd_chk("R1 cmp", 4'd2, 32'h0);
        rd_chk("R1 lit cmp", 4'd9, 32'h0);
        acc_chk("R1 passthrough", 32'h1040_1A04, 1'b0, 32'h1040_1A04, 1'b0);
    endtask

    task automatic t_ctrl_key;
        wr(4'd0, 32'h1);
        rd_chk("R2 keyless ignored", 4'd0, 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd_chk("R2 keyed enable", 4'd0, 32'h1);
    endtask

    task automatic t_base;
        wr(4'd1, 32'h2000_1234);
        rd_chk("R9 base align", 4'd1, 32'h2000_1220);
        wr(4'd1, 32'hFFFF_FFFF);
        rd_chk("R9 base fields", 4'd1, 32'h3FFF_FFE0);
        wr(4'd1, 32'h2000_0100);
    endtask

    task automatic t_match;
        wr(4'd2, 32'h1040_1A05);
        rd_chk("R4 cmp readback", 4'd2, 32'h1040_1A05);
        acc_chk("R6 slot0", 32'h1040_1A04, 1'b0, 32'h2000_0100, 1'b1);
        acc_chk("R6 byte lane", 32'h1040_1A06, 1'b0, 32'h2000_0102, 1'b1);
        wr(4'd3, 32'hF000_0007);
        rd_chk("R4 cmp unused bits", 4'd3, 32'h1000_0005);
        wr(4'd3, 32'h0000_0200);
        acc_chk("R4 even never matches", 32'h0000_0200, 1'b0, 32'h0000_0200, 1'b0);
    endtask

    task automatic t_literal;
        wr(4'd8, 32'h0000_0301);
        acc_chk("R5 fetch ignores lit cmp", 32'h0000_0300, 1'b0, 32'h0000_0300, 1'b0);
        acc_chk("R5 lit slot6", 32'h0000_0300, 1'b1, 32'h2000_0118, 1'b1);
        acc_chk("R5 lit ignores fetch cmp", 32'h1040_1A04, 1'b1, 32'h1040_1A04, 1'b0);
        wr(4'd9, 32'h0000_0305);
        acc_chk("R6 lit slot7", 32'h0000_0304, 1'b1, 32'h2000_011C, 1'b1);
    endtask

    task automatic t_priority;
        wr(4'd5, 32'h0000_0401);
        wr(4'd4, 32'h0000_0401);
        acc_chk("R7 lowest wins", 32'h0000_0400, 1'b0, 32'h2000_0108, 1'b1);
        wr(4'd4, 32'h0000_0400);
        acc_chk("R7 next after disable", 32'h0000_0400, 1'b0, 32'h2000_010C, 1'b1);
    endtask

    task automatic t_region;
        acc_chk("R8 high bits block", 32'h3040_1A04, 1'b0, 32'h3040_1A04, 1'b0);
        acc_chk("R8 sram pass", 32'h2000_0100, 1'b0, 32'h2000_0100, 1'b0);
    endtask

    task automatic t_global_off;
        wr(4'd0, 32'h2);
        acc_chk("R3 disabled", 32'h1040_1A04, 1'b0, 32'h1040_1A04, 1'b0);
        wr(4'd0, 32'h3);
        acc_chk("R3 re-enabled", 32'h1040_1A04, 1'b0, 32'h2000_0100, 1'b1);
    endtask

    task automatic t_timing;
        @(negedge clk);
        req_addr = 32'h0000_0500; req_is_lit = 1'b0;
        cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 32'h0000_0501;
        #1 chk("R10 before edge", out_addr, 32'h0000_0500);
        @(posedge clk);
        #1 chk("R10 after edge", out_addr, 32'h2000_0114);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_key();
        t_base();
        t_match();
        t_literal();
        t_priority();
        t_region();
        t_global_off();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule